// File: doc/BRIEF.md
# Ring Loop Tap Controller

This block sits between the receive and transmit pins of a serial channel that is one station on a bit-oriented ring. It chooses, bit by bit, what leaves on the transmit line. There are three choices: the receive line wired straight through with no register in the path, the receive line delayed by one bit clock, or the channel's own outgoing bits. A small byte shifter stands in for the channel's transmitter. It sends flags, or a data byte supplied on `txData` when `txBufFull` is high. Bits go out least significant first.

The station joins the ring in two steps. Both steps are triggered by the end-of-poll pattern on the receive line, and the poll-grant input `pollGo` must be high when the pattern is seen. The end-of-poll pattern is a 0 followed by seven 1s. The first qualified end-of-poll moves the block from straight-through wiring into the one-bit-delay repeat state. A later qualified end-of-poll hands it control of the ring, and it then sends an opening flag. Each time one of its own flags finishes, the block checks `pollGo` again. If the bit is high, it keeps transmitting. If the bit is low, it lets that flag end and drops back to repeating. After dropping back, it must see a flag (01111110) and then a fresh end-of-poll before it can take control again. Clearing `loopEn` returns it to straight-through wiring.

Top module: `ring_tap_ctrl`

## Requirements
- R1: While `onLoop` is 0, `txLine` equals `rxLine` in the same cycle, with no clock edge in between.
- R2: The block leaves straight-through only on the clock edge after the receive history holds the end-of-poll pattern (received in order 0,1,1,1,1,1,1,1) while `loopEn` and `pollGo` are high. It then sets `onLoop`. An end-of-poll seen while `pollGo` is low leaves it in straight-through.
- R3: While `onLoop` is 1 and `txActive` is 0, `txLine` equals the `rxLine` value of the previous bit clock.
- R4: From the repeat state, `txActive` rises only on a qualified end-of-poll with `pollGo` high. The end-of-poll that caused the insertion does not also activate. The first bits sent are the flag 01111110.
- R5: While active, at the last bit of each byte the next byte is chosen. After a data byte, the next byte is `txData` if `txBufFull` is high, otherwise a flag. After a flag, the same choice is made, but only if `pollGo` is high.
- R6: If `pollGo` is low when the last bit of a flag is being sent, that flag completes and the block returns to the repeat state (`txActive` 0, `onLoop` 1) on the next edge.
- R7: After returning from active, an end-of-poll with `pollGo` high does not activate the block until a flag has been received in the repeat state. Only an end-of-poll after that flag activates it.
- R8: Reset, or `loopEn` low at a clock edge, puts the block in straight-through with both status outputs 0. While `loopEn` is low, `pollGo` and end-of-poll patterns have no effect.
- R9: `onLoop` and `txActive` are register outputs. They change only at rising edges of `clk`, and `txActive` is never 1 while `onLoop` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loopEn | input | 1 | Ring loop operation enable |
| pollGo | input | 1 | Poll-grant control: permits insertion and taking control |
| txBufFull | input | 1 | A data byte is waiting on txData |
| txData | input | 8 | Data byte to send, least significant bit first |
| rxLine | input | 1 | Receive serial line |
| txLine | output | 1 | Transmit serial line |
| onLoop | output | 1 | Station is inserted (repeating or transmitting) |
| txActive | output | 1 | Station is sending its own bits |

## Verification
The properties assume that `loopEn`, `pollGo` and `rxLine` are stable across each rising edge. They also assume that `rstN` is the only way to clear state other than `loopEn`. The pass-through and delay checks compare `txLine` with `rxLine` sampled at the clock, so they assume the receive line changes only once per bit period. The stimulus follows these assumptions: every input change happens on the falling edge, and all control inputs are held for whole bit periods.

// File: rtl/ring_tap_pkg.sv
package ring_tap_pkg;

  typedef enum logic [1:0] {
    ST_PASS   = 2'd0,
    ST_REPEAT = 2'd1,
    ST_ACTIVE = 2'd2
  } tap_state_e;

  typedef enum logic [1:0] {
    RT_WIRE  = 2'd0,
    RT_DELAY = 2'd1,
    RT_OWN   = 2'd2
  } tap_route_e;

  // control -> datapath
  typedef struct packed {
    tap_route_e route;
    logic       loadFlag;
    logic       loadData;
    logic       shiftEn;
  } tap_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic eopSeen;
    logic flagSeen;
    logic lastBit;
    logic curIsFlag;
  } tap_obs_t;

endpackage

// File: rtl/ring_tap_datapath.sv
module ring_tap_datapath
  import ring_tap_pkg::*;
#(
  parameter int ByteW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [ByteW-1:0] txData,
  input  tap_strobe_t      strobe,
  output logic             txLine,
  output tap_obs_t         obs
);
  localparam int CntW = $clog2(ByteW);
  localparam logic [ByteW-1:0] FlagPat = {1'b0, {(ByteW-2){1'b1}}, 1'b0};
  localparam logic [ByteW-1:0] EopPat  = {1'b0, {(ByteW-1){1'b1}}};
  localparam logic [CntW-1:0]  LastCnt = CntW'(ByteW - 1);

  logic [ByteW-1:0] rxHist;
  logic             rxDly;
  logic [ByteW-1:0] txShift;
  logic [CntW-1:0]  bitCnt;
  logic             curFlag;

  // receive history, oldest bit in the MSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHist <= '0;
      rxDly  <= 1'b1;
    end else begin
      rxHist <= {rxHist[ByteW-2:0], rxLine};
      rxDly  <= rxLine;
    end
  end

  // stand-in transmitter, LSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      bitCnt  <= '0;
      curFlag <= 1'b0;
    end else if (strobe.loadFlag) begin
      txShift <= FlagPat;
      bitCnt  <= '0;
      curFlag <= 1'b1;
    end else if (strobe.loadData) begin
      txShift <= txData;
      bitCnt  <= '0;
      curFlag <= 1'b0;
    end else if (strobe.shiftEn) begin
      txShift <= {1'b1, txShift[ByteW-1:1]};
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    obs.eopSeen   = (rxHist == EopPat);
    obs.flagSeen  = (rxHist == FlagPat);
    obs.lastBit   = (bitCnt == LastCnt);
    obs.curIsFlag = curFlag;
  end

  always_comb begin
    unique case (strobe.route)
      RT_DELAY: txLine = rxDly;
      RT_OWN:   txLine = txShift[0];
      default:  txLine = rxLine;
    endcase
  end

endmodule

// File: rtl/ring_tap_control.sv
module ring_tap_control
  import ring_tap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loopEn,
  input  logic        pollGo,
  input  logic        txBufFull,
  input  tap_obs_t    obs,
  output tap_strobe_t strobe,
  output logic        onLoop,
  output logic        txActive
);
  tap_state_e state, stateNxt;
  logic       needFlag, needFlagNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PASS;
      needFlag <= 1'b0;
    end else begin
      state    <= stateNxt;
      needFlag <= needFlagNxt;
    end
  end

  always_comb begin
    stateNxt    = state;
    needFlagNxt = needFlag;
    strobe      = '0;
    unique case (state)
      ST_REPEAT: strobe.route = RT_DELAY;
      ST_ACTIVE: strobe.route = RT_OWN;
      default:   strobe.route = RT_WIRE;
    endcase

    if (!loopEn) begin
      stateNxt    = ST_PASS;
      needFlagNxt = 1'b0;
    end else begin
      unique case (state)
        ST_PASS: begin
          if (pollGo && obs.eopSeen) stateNxt = ST_REPEAT;
        end
        ST_REPEAT: begin
          if (obs.flagSeen) needFlagNxt = 1'b0;
          if (pollGo && obs.eopSeen && !needFlag) begin
            stateNxt        = ST_ACTIVE;
            strobe.loadFlag = 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (obs.lastBit) begin
            if (obs.curIsFlag && !pollGo) begin
              stateNxt    = ST_REPEAT;
              needFlagNxt = 1'b1;
            end else if (txBufFull) begin
              strobe.loadData = 1'b1;
            end else begin
              strobe.loadFlag = 1'b1;
            end
          end else begin
            strobe.shiftEn = 1'b1;
          end
        end
        default: stateNxt = ST_PASS;
      endcase
    end
  end

  assign onLoop   = (state != ST_PASS);
  assign txActive = (state == ST_ACTIVE);

endmodule

// File: rtl/ring_tap_ctrl.sv
module ring_tap_ctrl
  import ring_tap_pkg::*;
#(
  parameter int ByteW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loopEn,
  input  logic             pollGo,
  input  logic             txBufFull,
  input  logic [ByteW-1:0] txData,
  input  logic             rxLine,
  output logic             txLine,
  output logic             onLoop,
  output logic             txActive
);
  tap_strobe_t strobe;
  tap_obs_t    obs;

  ring_tap_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loopEn    (loopEn),
    .pollGo    (pollGo),
    .txBufFull (txBufFull),
    .obs       (obs),
    .strobe    (strobe),
    .onLoop    (onLoop),
    .txActive  (txActive)
  );

  ring_tap_datapath #(.ByteW(ByteW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .rxLine (rxLine),
    .txData (txData),
    .strobe (strobe),
    .txLine (txLine),
    .obs    (obs)
  );

endmodule

// File: rtl/ring_tap_chk.sv
module ring_tap_chk (
  input logic clk,
  input logic rstN,
  input logic loopEn,
  input logic pollGo,
  input logic rxLine,
  input logic txLine,
  input logic onLoop,
  input logic txActive
);

  // R8
  loop_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loopEn |=> (!onLoop && !txActive));

  // R1
  wire_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    !onLoop |-> (txLine == rxLine));

  // R2
  insert_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onLoop) |-> ($past(pollGo) && $past(loopEn)));

  // R3
  delay_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (onLoop && !txActive && $past(onLoop)) |-> (txLine == $past(rxLine)));

  // R4
  take_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> ($past(pollGo) && $past(onLoop)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txActive) && onLoop) |-> !$past(pollGo));

  // R9
  status_nest_chk: assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> onLoop);

endmodule

bind ring_tap_ctrl ring_tap_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loopEn   (loopEn),
  .pollGo   (pollGo),
  .rxLine   (rxLine),
  .txLine   (txLine),
  .onLoop   (onLoop),
  .txActive (txActive)
);

// File: tb/ring_tap_ctrl_tb.sv
module ring_tap_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loopEn = 1'b0;
  logic       pollGo = 1'b0;
  logic       txBufFull = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       rxLine = 1'b1;
  logic       txLine, onLoop, txActive;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ring_tap_ctrl u_dut (
    .clk(clk), .rstN(rstN), .loopEn(loopEn), .pollGo(pollGo),
    .txBufFull(txBufFull), .txData(txData), .rxLine(rxLine),
    .txLine(txLine), .onLoop(onLoop), .txActive(txActive)
  );

  typedef struct {
    logic  tx;
    logic  on;
    logic  act;
    string tag;
  } exp_t;
  exp_t q[$];

  // settings applied at the next driven bit
  logic       cLoop = 0, cPoll = 0, cFull = 0;
  logic [7:0] cData = 8'h00;
  logic [7:0] lfsr = 8'h5B;

  // reference model state (0 wire, 1 repeat, 2 active)
  int         mSt = 0;
  logic [7:0] mHist = 8'h00;
  logic       mDly = 1'b1;
  logic       mNeed = 1'b0;
  logic [7:0] mSh = 8'hFF;
  int         mCnt = 0;
  logic       mIsFlag = 1'b0;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item pushed for this bit period
  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " txLine"}, txLine, e.tx);
      check({e.tag, " onLoop (R9)"}, onLoop, e.on);
      check({e.tag, " txActive (R9)"}, txActive, e.act);
    end
  end

  // driver: one bit period
  task automatic drive(input logic rx, input string tag);
    exp_t e;
    logic eop, flg;
    @(negedge clk);
    rstN = 1'b1;
    rxLine = rx; loopEn = cLoop; pollGo = cPoll;
    txBufFull = cFull; txData = cData;
    e.tx  = (mSt == 0) ? rx : (mSt == 1) ? mDly : mSh[0];
    e.on  = (mSt != 0);
    e.act = (mSt == 2);
    e.tag = tag;
    q.push_back(e);
    // model of the coming rising edge
    eop = (mHist == 8'h7F);
    flg = (mHist == 8'h7E);
    if (!cLoop) begin
      mSt = 0; mNeed = 0;
    end else if (mSt == 0) begin
      if (cPoll && eop) mSt = 1;
    end else if (mSt == 1) begin
      if (flg) mNeed = 0;
      if (cPoll && eop && !mNeed) begin
        mSt = 2; mSh = 8'h7E; mCnt = 0; mIsFlag = 1;
      end
    end else begin
      if (mCnt == 7) begin
        if (mIsFlag && !cPoll) begin
          mSt = 1; mNeed = 1;
        end else if (cFull) begin
          mSh = cData; mCnt = 0; mIsFlag = 0;
        end else begin
          mSh = 8'h7E; mCnt = 0; mIsFlag = 1;
        end
      end else begin
        mSh = {1'b1, mSh[7:1]}; mCnt++;
      end
    end
    mHist = {mHist[6:0], rx};
    mDly = rx;
  endtask

  task automatic sendByte(input logic [7:0] v, input string tag);
    for (int i = 7; i >= 0; i--) drive(v[i], tag);
  endtask

  task automatic sendRand(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(lfsr[0], tag);
    end
  endtask

  task automatic sendOnes(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rxLine = 1'b0;
    #1;
    check("R8 reset onLoop", onLoop, 1'b0);
    check("R8 reset txActive", txActive, 1'b0);
    check("R1 reset wire", txLine, 1'b0);

    // loop disabled: poll and end-of-poll have no effect
    cLoop = 0; cPoll = 1;
    sendByte(8'h7F, "R8 loop off");
    sendRand(6, "R8 loop off");

    // loop on, poll low: end-of-poll ignored
    cLoop = 1; cPoll = 0;
    sendRand(10, "R1 wire");
    sendByte(8'h7F, "R2 eop without poll");
    sendOnes(3, "R2 eop without poll");

    // insertion
    cPoll = 1;
    sendByte(8'h7F, "R2 insert");
    sendRand(12, "R3 repeat");

    // take control, flag then data bytes then flags
    sendByte(8'h7F, "R4 take control");
    sendOnes(2, "R4 opening flag");
    cFull = 1; cData = 8'hA5;
    sendRand(12, "R5 data byte");
    cData = 8'h3C;
    sendRand(8, "R5 data byte");
    cFull = 0;
    sendRand(12, "R5 flag after data");
    cPoll = 0;
    sendRand(20, "R6 release");

    // re-arm needs a flag first
    cPoll = 1;
    sendOnes(8, "R7 repeat");
    sendByte(8'h7F, "R7 eop before flag");
    sendOnes(4, "R7 still repeating");
    sendByte(8'h7E, "R7 flag");
    sendByte(8'h7F, "R7 eop after flag");
    sendOnes(6, "R7 active again");
    cPoll = 0;
    sendOnes(14, "R6 release again");

    // leave loop mode
    cLoop = 0; cPoll = 1;
    sendRand(4, "R8 loop dropped");
    sendByte(8'h7F, "R8 loop dropped");
    sendRand(4, "R1 wire again");

    @(negedge clk);
    #5;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule